// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the rising edges of the IF input inside a gate window of known length. A rising edge on the start control bit arms the sequence. The block first waits a fixed 3.5 ms so that the input can settle. It then opens a gate of 4, 8, 16 or 32 ms and counts IF edges while the gate is open. When the gate closes, the count is latched into a result register, where it stays for serial readback. The block also raises an end flag.

All gate timing comes from a timebase that is derived from the system clock. A prescaler divides the clock by `CLK_PER_TB` to give timebase ticks, and `TB_PER_MS` ticks make one millisecond. The prescaler restarts at each start edge, so the wait and gate lengths are exact whole numbers of ticks. The IF input is asynchronous. It passes through a synchroniser and an edge detector before it reaches the counter. The count stops at all ones rather than wrapping.

The end flag can drive an open-drain status pin that works as an end-of-measurement handshake. The pin is released when a measurement starts and is pulled low when the measurement ends. It is released again whenever a serial transfer is in progress. Either clearing the start bit or an inhibit request from the synthesiser aborts a measurement at once. In both cases the last completed result is kept.

Top module: `if_freq_counter`

## Requirements
- R1: After reset, `count_o` is 0, `busy_o` is 0, `done_o` is 0 and `do_n_o` is 1 (released).
- R2: A rising edge on `start_i` while `inhibit_i` is low starts a measurement. `busy_o` is 1 and `done_o` is 0 from the following cycle. `gate_sel_i` is captured at that edge.
- R3: Before the gate opens there is a wait of (7*`TB_PER_MS`)/2 timebase ticks (3.5 ms). IF edges that arrive during the wait are not counted.
- R4: `gate_sel_i` selects the gate length: 0 gives 4 ms, 1 gives 8 ms, 2 gives 16 ms and 3 gives 32 ms, each being `TB_PER_MS` ticks per ms. `done_o` rises, and `busy_o` falls, exactly (wait + gate) × `CLK_PER_TB` clock cycles after the start edge is sampled.
- R5: At the end of the gate, `count_o` holds the number of rising IF edges seen during the gate window, as a `CNT_W`-bit binary value (bit `CNT_W`-1 is the MSB, default 20 bits).
- R6: If more than 2^`CNT_W`-1 edges arrive, the result saturates at all ones.
- R7: Driving `start_i` low during a measurement returns the block to idle on the next cycle. `count_o` keeps its previous value and `done_o` stays 0.
- R8: While `inhibit_i` is high, any measurement is aborted on the next cycle and start edges are ignored.
- R9: With `do_sel_i` = 3'b010 and `ce_i` low, `do_n_o` is 0 while `done_o` is 1 and is 1 otherwise. Any other `do_sel_i` value leaves `do_n_o` at 1.
- R10: While `ce_i` is high, `do_n_o` is 1 regardless of the other inputs.
- R11: `count_o` changes only at the end of a completed gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System and reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Count-enable control bit. A rising edge starts a measurement; low aborts it |
| gate_sel_i | input | 2 | Gate length select (4/8/16/32 ms) |
| inhibit_i | input | 1 | Synthesiser inhibit. Stops and blocks counting |
| if_i | input | 1 | Asynchronous IF input |
| ce_i | input | 1 | Serial transfer in progress. Releases the status pin |
| do_sel_i | input | 3 | Status pin function select. 3'b010 selects end-of-count |
| count_o | output | CNT_W | Latched measurement result |
| busy_o | output | 1 | Measurement in progress (wait or gate) |
| done_o | output | 1 | End flag. Set when a gate completes; cleared at start |
| do_n_o | output | 1 | Open-drain status pin: 0 = pull low, 1 = released |

## Verification
Each measurement runs against a free-running IF square wave that is active through both the wait and the gate. For every gate length, the wave period is chosen so that the gate spans a whole number of periods. A result equal to gate cycles divided by period therefore shows that the wait was excluded and that the gate has the selected length. Any edge leaking in from the wait would inflate the result. The same gate is run with two different periods, which separates correct edge counting from a fixed or scaled value. The longest gate with the shortest period overruns the reduced counter width and exercises saturation. Abort by the start bit, abort by inhibit, and start edges blocked by inhibit are each checked against the previous result and the timing of the end flag.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GATE = 2'd2
  } ifc_state_e;

  localparam logic [2:0] DO_SEL_END = 3'b010;
endpackage

// File: rtl/ifc_timebase.sv
module ifc_timebase #(
  parameter int CLK_PER_TB = 45
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PRE_W = $clog2(CLK_PER_TB) + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_TB - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = (pre_q == PRE_LAST) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clr_i || tick_o)    pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ifc_edge_counter.sv
module ifc_edge_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             if_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic sync1_q, sync2_q, prev_q, pulse;
  logic [CNT_W-1:0] cnt_q;
  logic sat;

  assign pulse = sync2_q & ~prev_q;
  assign sat   = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= if_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    cnt_next_o = cnt_q;
    if (clr_i)                        cnt_next_o = '0;
    else if (en_i && pulse && !sat)   cnt_next_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat && !clr_i) |=> (&cnt_q)); // R6
endmodule

// File: rtl/ifc_sequencer.sv
module ifc_sequencer
  import ifc_pkg::*;
#(
  parameter int TB_PER_MS = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       inhibit_i,
  input  logic [1:0] gate_sel_i,
  input  logic       tick_i,
  output ifc_state_e state_o,
  output logic       launch_o,
  output logic       finish_o
);
  localparam int WAIT_TB  = (7 * TB_PER_MS) / 2;
  localparam int GATE_MAX = 32 * TB_PER_MS;
  localparam int TB_W     = $clog2(GATE_MAX + 1);
  localparam logic [TB_W-1:0] WAIT_LAST = TB_W'(WAIT_TB - 1);

  ifc_state_e state_q;
  logic start_q;
  logic [1:0] sel_q;
  logic [TB_W-1:0] tb_q, gate_last;

  always_comb begin
    case (sel_q)
      2'd0:    gate_last = TB_W'(4 * TB_PER_MS - 1);
      2'd1:    gate_last = TB_W'(8 * TB_PER_MS - 1);
      2'd2:    gate_last = TB_W'(16 * TB_PER_MS - 1);
      default: gate_last = TB_W'(32 * TB_PER_MS - 1);
    endcase
  end

  assign launch_o = start_i && !start_q && !inhibit_i;
  assign finish_o = (state_q == ST_GATE) && tick_i && (tb_q == gate_last)
                    && start_i && !inhibit_i;
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      sel_q   <= 2'd0;
      tb_q    <= '0;
    end else begin
      start_q <= start_i;
      if (launch_o) begin
        state_q <= ST_WAIT;
        sel_q   <= gate_sel_i;
        tb_q    <= '0;
      end else if (!start_i || inhibit_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        case (state_q)
          ST_WAIT: begin
            if (tb_q == WAIT_LAST) begin
              state_q <= ST_GATE;
              tb_q    <= '0;
            end else tb_q <= tb_q + 1'b1;
          end
          ST_GATE: begin
            if (tb_q == gate_last) state_q <= ST_IDLE;
            else                   tb_q    <= tb_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !start_i) |=> (state_q == ST_IDLE)); // R7
  AST_INHIBIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> (state_q == ST_IDLE)); // R8
  AST_WAIT_TICKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !tick_i) |=> (state_q != ST_GATE)); // R3
endmodule

// File: rtl/if_freq_counter.sv
module if_freq_counter
  import ifc_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int CLK_PER_TB = 45,
  parameter int TB_PER_MS  = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             inhibit_i,
  input  logic             if_i,
  input  logic             ce_i,
  input  logic [2:0]       do_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             do_n_o
);
  ifc_state_e state;
  logic launch, finish, tick;
  logic [CNT_W-1:0] cnt_next, result_q;
  logic done_q;

  ifc_timebase #(.CLK_PER_TB(CLK_PER_TB)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .tick_o (tick)
  );

  ifc_sequencer #(.TB_PER_MS(TB_PER_MS)) u_sequencer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .inhibit_i  (inhibit_i),
    .gate_sel_i (gate_sel_i),
    .tick_i     (tick),
    .state_o    (state),
    .launch_o   (launch),
    .finish_o   (finish)
  );

  ifc_edge_counter #(.CNT_W(CNT_W)) u_edge_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .if_i       (if_i),
    .clr_i      (launch),
    .en_i       (state == ST_GATE),
    .cnt_next_o (cnt_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else if (launch) begin
      done_q   <= 1'b0;
    end else if (finish) begin
      result_q <= cnt_next;
      done_q   <= 1'b1;
    end
  end

  assign count_o = result_q;
  assign busy_o  = (state != ST_IDLE);
  assign done_o  = done_q;
  // open-drain: 0 pulls low, 1 releases
  assign do_n_o  = ce_i || (do_sel_i != DO_SEL_END) || !done_q;

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_GATE) |=> $stable(result_q)); // R11
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (!busy_o && $past(busy_o))); // R4
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (busy_o && !done_q)); // R2
endmodule

// File: tb/test_if_freq_counter.sv
module test_if_freq_counter;
  localparam int CNT_W = 6;
  localparam int CPT   = 2;
  localparam int TPM   = 4;
  localparam int WAIT_TB = (7 * TPM) / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] gate_sel_i = 2'd0;
  logic inhibit_i = 1'b0;
  logic if_i = 1'b0;
  logic ce_i = 1'b0;
  logic [2:0] do_sel_i = 3'b010;
  logic [CNT_W-1:0] count_o;
  logic busy_o, done_o, do_n_o;

  int checks = 0;
  int fails = 0;
  int if_period = 4;
  int if_k = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if_k = if_k + 1;
    if_i = ((if_k % if_period) < (if_period / 2));
  end

  if_freq_counter #(.CNT_W(CNT_W), .CLK_PER_TB(CPT), .TB_PER_MS(TPM)) i_if_freq_counter (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .gate_sel_i(gate_sel_i),
    .inhibit_i(inhibit_i), .if_i(if_i), .ce_i(ce_i), .do_sel_i(do_sel_i),
    .count_o(count_o), .busy_o(busy_o), .done_o(done_o), .do_n_o(do_n_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int total_cycles(int sel);
    return (WAIT_TB + (4 * TPM << sel)) * CPT;
  endfunction

  // full measurement; checks end timing and result
  task automatic measure(int sel, int period, int exp_cnt, string req);
    @(negedge clk);
    if_period = period;
    gate_sel_i = 2'(sel);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R2 done cleared", int'(done_o), 0);
    repeat (total_cycles(sel) - 1) @(negedge clk);
    chk("R4 not done before end", int'(done_o), 0);
    @(negedge clk);
    chk("R4 done at end", int'(done_o), 1);
    chk("R4 idle at end", int'(busy_o), 0);
    chk(req, int'(count_o), exp_cnt);
    start_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", int'(count_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 do", int'(do_n_o), 1);
  endtask

  task automatic t_gates;
    measure(0, 4, 8, "R3 R5 sel0 period4");
    measure(0, 8, 4, "R5 sel0 period8");
    measure(1, 4, 16, "R4 R5 sel1");
    measure(2, 8, 16, "R4 R5 sel2");
    measure(3, 8, 32, "R4 R5 sel3");
    measure(3, 4, 63, "R6 saturation");
  endtask

  task automatic t_do_pin;
    // done_o is 1 from the previous measurement
    do_sel_i = 3'b010; ce_i = 1'b0; #1;
    chk("R9 low when done", int'(do_n_o), 0);
    ce_i = 1'b1; #1;
    chk("R10 ce releases", int'(do_n_o), 1);
    ce_i = 1'b0; do_sel_i = 3'b001; #1;
    chk("R9 other select open", int'(do_n_o), 1);
    do_sel_i = 3'b010;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk);
    chk("R9 released at start", int'(do_n_o), 1);
    start_i = 1'b0;
  endtask

  task automatic t_abort;
    int prev;
    measure(0, 8, 4, "R5 baseline");
    prev = int'(count_o);
    if_period = 4; gate_sel_i = 2'd1;
    @(negedge clk); start_i = 1'b1;
    repeat (50) @(negedge clk);
    chk("R7 busy in gate", int'(busy_o), 1);
    start_i = 1'b0;
    @(negedge clk);
    chk("R7 idle after abort", int'(busy_o), 0);
    repeat (total_cycles(1)) @(negedge clk);
    chk("R7 done stays 0", int'(done_o), 0);
    chk("R7 R11 result kept", int'(count_o), prev);
  endtask

  task automatic t_inhibit;
    int prev;
    prev = int'(count_o);
    @(negedge clk); inhibit_i = 1'b1; start_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 start ignored", int'(busy_o), 0);
    start_i = 1'b0; inhibit_i = 1'b0;
    @(negedge clk); start_i = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 running", int'(busy_o), 1);
    inhibit_i = 1'b1;
    @(negedge clk);
    chk("R8 aborted", int'(busy_o), 0);
    inhibit_i = 1'b0;
    repeat (total_cycles(1)) @(negedge clk);
    chk("R8 no done", int'(done_o), 0);
    chk("R8 R11 result kept", int'(count_o), prev);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_gates();
    t_do_pin();
    t_abort();
    t_inhibit();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule